// File: doc/BRIEF.md
# Voice Interrupt Source Arbiter

This block gathers interrupt requests from a bank of synthesis voices. There are two classes of request: wavetable loop end and volume ramp end. Each class keeps its own pending vector and a matching per-voice status flag. The voices raise requests through one-cycle strobes. Each class also keeps a summary bit in the global interrupt status byte, and the block drives a shared interrupt line that is the OR of that byte.

Software selects a function by writing a code to the function-select register. Writing the service code 0x8F runs one service cycle. That cycle picks a single source, clears its pending bit and its per-voice flag, and latches an identification byte. When the function select holds the service code, the identification byte can be read back on the read-data port as often as needed.

Top module: `vi_arb`

## Requirements
- R1: A write of 0x8F on the function-select port runs exactly one service cycle, which clears at most one pending bit. A write of any other code only updates the function select and services nothing.
- R2: Within the chosen class, the service picks the lowest pending voice index among voices 0 to 30. Voice 31 can be pending but is never serviced.
- R3: If any wavetable bit is pending, including voice 31, the service works on the wavetable class and leaves the ramp vector untouched. With only voice 31 pending in the wavetable vector, the latched byte is 0xE8.
- R4: Servicing wavetable voice v clears wavetable pending bit v and wavetable flag v, and latches 0x60 | v.
- R5: Servicing ramp voice v clears ramp pending bit v and ramp flag v, and latches 0x80 | v.
- R6: When the service finds no eligible source, it latches 0xE8.
- R7: While the function select equals 0x8F, read data shows the latched byte; for any other select it shows 0xFF. Reading changes no state.
- R8: Status bit 5 is set by any wavetable request. It is cleared only by a wavetable service after which no wavetable bit remains pending. Status bit 6 behaves the same way for the ramp class.
- R9: The status byte is {ext[5], bit6, bit5, ext[4:0]}. The interrupt line is high exactly when this byte is nonzero.
- R10: A request for a voice in the same cycle as that voice's clear wins: the pending bit and the flag stay set, and the class summary bit stays set.
- R11: After synchronous reset, both pending vectors, both flag vectors and both summary bits are zero, the function select is 0x00, and the latched byte is 0xE8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| func_we | input | 1 | Write strobe for the function-select register |
| func_wdata | input | 8 | Function code to write |
| wt_req | input | NUM_VOICES | One-cycle wavetable request strobes, one per voice |
| rmp_req | input | NUM_VOICES | One-cycle volume ramp request strobes, one per voice |
| ext_bits | input | 6 | Other interrupt sources, placed in status bits 7 and 4..0 |
| rd_data | output | 8 | Latched identification byte, or 0xFF |
| wt_pend | output | NUM_VOICES | Wavetable pending vector |
| rmp_pend | output | NUM_VOICES | Ramp pending vector |
| wt_flag | output | NUM_VOICES | Per-voice wavetable interrupt flag |
| rmp_flag | output | NUM_VOICES | Per-voice ramp interrupt flag |
| irq_status | output | 8 | Global interrupt status byte |
| irq | output | 1 | Shared interrupt line |

## Verification
A wrong pending bit shows up on the pending port one cycle after the strobe or service write that caused it. A wrong pick shows up in the identification byte on the next read after that same service write. An error in the summary logic shows up on bits 5 and 6 of the status byte and on the interrupt line. Such an error can stay hidden until the class empties, so the bench drains each class fully and checks the status byte after the last service. The bench also feeds a request for voice 31 on its own, because the class choice sees voice 31 while the scan never picks it. A mismatch between the two is the hardest fault to notice, since it shows up only as a ramp request that never gets served.

// File: rtl/vi_pkg.sv
package vi_pkg;
    localparam logic [7:0] FN_SERVICE  = 8'h8F;
    localparam logic [7:0] ID_NONE     = 8'hE8;
    localparam logic [7:0] MARK_WT     = 8'h60;
    localparam logic [7:0] MARK_RMP    = 8'h80;
    localparam logic [7:0] RD_IDLE     = 8'hFF;
    localparam logic [7:0] FN_RESET    = 8'h00;
    localparam int unsigned WT_SUM_BIT  = 5;
    localparam int unsigned RMP_SUM_BIT = 6;

    typedef enum logic [1:0] {
        SRC_NONE = 2'd0,
        SRC_WT   = 2'd1,
        SRC_RMP  = 2'd2
    } src_e;

    typedef struct packed {
        src_e       cls;
        logic       hit;
        logic [7:0] id;
    } svc_s;

    function automatic logic [7:0] make_id(input logic [7:0] mark, input int unsigned idx);
        return mark | 8'(idx);
    endfunction
endpackage

// File: rtl/vi_pend_bank.sv
module vi_pend_bank #(
    parameter int unsigned NUM_VOICES = 32
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [NUM_VOICES-1:0] req,
    input  logic [NUM_VOICES-1:0] clr,
    input  logic                  svc,
    output logic [NUM_VOICES-1:0] pend,
    output logic [NUM_VOICES-1:0] flag,
    output logic                  summ
);
    logic [NUM_VOICES-1:0] kept;
    logic                  any_req;
    logic                  drained;

    assign kept    = pend & ~clr;
    assign any_req = |req;
    assign drained = svc && (kept == '0) && !any_req;

    for (genvar v = 0; v < NUM_VOICES; v++) begin : g_voice
        always_ff @(posedge clk) begin
            if (rst) begin
                pend[v] <= 1'b0;
                flag[v] <= 1'b0;
            end else begin
                pend[v] <= (pend[v] & ~clr[v]) | req[v];
                flag[v] <= (flag[v] & ~clr[v]) | req[v];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst)          summ <= 1'b0;
        else if (any_req) summ <= 1'b1;
        else if (drained) summ <= 1'b0;
    end

    p_req_wins_r10: assert property (@(posedge clk) disable iff (rst)
        (|req) |=> (((pend & flag) & $past(req)) == $past(req)));
    p_clear_hits_r4: assert property (@(posedge clk) disable iff (rst)
        (|clr) |=> (((pend | flag) & $past(clr & ~req)) == '0));
    p_sum_set_r8: assert property (@(posedge clk) disable iff (rst)
        (|req) |=> summ);
    p_sum_hold_r8: assert property (@(posedge clk) disable iff (rst)
        (!svc && !(|req)) |=> $stable(summ));
endmodule

// File: rtl/vi_pick.sv
module vi_pick
    import vi_pkg::*;
#(
    parameter int unsigned NUM_VOICES = 32,
    parameter int unsigned SCAN_VOICES = 31
) (
    input  logic [NUM_VOICES-1:0] wt_pend,
    input  logic [NUM_VOICES-1:0] rmp_pend,
    output svc_s                  pick,
    output logic [NUM_VOICES-1:0] wt_sel,
    output logic [NUM_VOICES-1:0] rmp_sel
);
    logic [NUM_VOICES-1:0] win;
    logic [NUM_VOICES-1:0] first;
    logic                  found;
    logic [7:0]            idx_id;
    logic [7:0]            mark;

    always_comb begin
        if (|wt_pend) begin
            pick.cls = SRC_WT;
            win      = wt_pend;
            mark     = MARK_WT;
        end else if (|rmp_pend) begin
            pick.cls = SRC_RMP;
            win      = rmp_pend;
            mark     = MARK_RMP;
        end else begin
            pick.cls = SRC_NONE;
            win      = '0;
            mark     = MARK_WT;
        end
    end

    always_comb begin
        first  = '0;
        found  = 1'b0;
        idx_id = ID_NONE;
        for (int i = 0; i < int'(SCAN_VOICES); i++) begin
            if (!found && win[i]) begin
                found    = 1'b1;
                first[i] = 1'b1;
                idx_id   = make_id(mark, i);
            end
        end
    end

    assign pick.hit = found;
    assign pick.id  = idx_id;
    assign wt_sel   = (pick.cls == SRC_WT)  ? first : '0;
    assign rmp_sel  = (pick.cls == SRC_RMP) ? first : '0;
endmodule

// File: rtl/vi_arb.sv
module vi_arb
    import vi_pkg::*;
#(
    parameter int unsigned NUM_VOICES  = 32,
    parameter int unsigned SCAN_VOICES = NUM_VOICES - 1
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  func_we,
    input  logic [7:0]            func_wdata,
    input  logic [NUM_VOICES-1:0] wt_req,
    input  logic [NUM_VOICES-1:0] rmp_req,
    input  logic [5:0]            ext_bits,
    output logic [7:0]            rd_data,
    output logic [NUM_VOICES-1:0] wt_pend,
    output logic [NUM_VOICES-1:0] rmp_pend,
    output logic [NUM_VOICES-1:0] wt_flag,
    output logic [NUM_VOICES-1:0] rmp_flag,
    output logic [7:0]            irq_status,
    output logic                  irq
);
    logic [7:0]            func_q;
    logic [7:0]            id_q;
    logic                  fire;
    svc_s                  pick;
    logic [NUM_VOICES-1:0] wt_sel;
    logic [NUM_VOICES-1:0] rmp_sel;
    logic [NUM_VOICES-1:0] wt_clr;
    logic [NUM_VOICES-1:0] rmp_clr;
    logic                  wt_sum;
    logic                  rmp_sum;

    assign fire    = func_we && (func_wdata == FN_SERVICE);
    assign wt_clr  = fire ? wt_sel  : '0;
    assign rmp_clr = fire ? rmp_sel : '0;

    vi_pick #(.NUM_VOICES(NUM_VOICES), .SCAN_VOICES(SCAN_VOICES)) u_pick (
        .wt_pend (wt_pend),
        .rmp_pend(rmp_pend),
        .pick    (pick),
        .wt_sel  (wt_sel),
        .rmp_sel (rmp_sel)
    );

    vi_pend_bank #(.NUM_VOICES(NUM_VOICES)) u_wt_bank (
        .clk (clk),
        .rst (rst),
        .req (wt_req),
        .clr (wt_clr),
        .svc (fire && (pick.cls == SRC_WT)),
        .pend(wt_pend),
        .flag(wt_flag),
        .summ(wt_sum)
    );

    vi_pend_bank #(.NUM_VOICES(NUM_VOICES)) u_rmp_bank (
        .clk (clk),
        .rst (rst),
        .req (rmp_req),
        .clr (rmp_clr),
        .svc (fire && (pick.cls == SRC_RMP)),
        .pend(rmp_pend),
        .flag(rmp_flag),
        .summ(rmp_sum)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            func_q <= FN_RESET;
            id_q   <= ID_NONE;
        end else if (func_we) begin
            func_q <= func_wdata;
            if (fire) id_q <= pick.id;
        end
    end

    assign rd_data    = (func_q == FN_SERVICE) ? id_q : RD_IDLE;
    assign irq_status = {ext_bits[5], rmp_sum, wt_sum, ext_bits[4:0]};
    assign irq        = |irq_status;

    p_one_src_r1: assert property (@(posedge clk) disable iff (rst)
        $countones({wt_clr, rmp_clr}) <= 1);
    p_no_fire_no_clr_r1: assert property (@(posedge clk) disable iff (rst)
        !fire |-> ({wt_clr, rmp_clr} == '0));
    p_wt_first_r3: assert property (@(posedge clk) disable iff (rst)
        (|wt_pend) |-> (rmp_clr == '0));
    p_id_form_r6: assert property (@(posedge clk) disable iff (rst)
        fire |=> ((id_q == ID_NONE) || (id_q[7:5] == 3'b011) || (id_q[7:5] == 3'b100)));
    p_hit_matches_r2: assert property (@(posedge clk) disable iff (rst)
        (fire && !pick.hit) |=> (id_q == ID_NONE));
    p_read_quiet_r7: assert property (@(posedge clk) disable iff (rst)
        !fire |=> $stable(id_q));
endmodule

// File: tb/vi_arb_bench.sv
`timescale 1ns/1ps
module vi_arb_bench;
    localparam int NV = 32;

    typedef struct {
        string       tag;
        int          kind;
        logic [31:0] exp;
    } item_t;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          func_we = 1'b0;
    logic [7:0]    func_wdata = 8'h00;
    logic [NV-1:0] wt_req = '0;
    logic [NV-1:0] rmp_req = '0;
    logic [5:0]    ext_bits = '0;
    logic [7:0]    rd_data;
    logic [NV-1:0] wt_pend, rmp_pend, wt_flag, rmp_flag;
    logic [7:0]    irq_status;
    logic          irq;

    int errors = 0;
    int checks = 0;
    bit done   = 1'b0;
    item_t q[$];

    logic [NV-1:0] mw, mr;
    logic          mws, mrs;
    logic [7:0]    msel, mlat;
    logic [5:0]    mext;

    always #2.5 clk = ~clk;

    vi_arb #(.NUM_VOICES(NV)) u_vi_arb (
        .clk(clk), .rst(rst), .func_we(func_we), .func_wdata(func_wdata),
        .wt_req(wt_req), .rmp_req(rmp_req), .ext_bits(ext_bits),
        .rd_data(rd_data), .wt_pend(wt_pend), .rmp_pend(rmp_pend),
        .wt_flag(wt_flag), .rmp_flag(rmp_flag), .irq_status(irq_status), .irq(irq)
    );

    function automatic logic [31:0] actual(int kind);
        case (kind)
            0: return {24'h0, rd_data};
            1: return wt_pend;
            2: return rmp_pend;
            3: return {24'h0, irq_status};
            4: return {31'h0, irq};
            5: return wt_flag;
            default: return rmp_flag;
        endcase
    endfunction

    // monitor: compares queued expectations at the falling edge
    initial begin
        forever begin
            @(negedge clk);
            while (q.size() > 0) begin
                item_t it;
                it = q.pop_front();
                checks++;
                if (actual(it.kind) !== it.exp) begin
                    errors++;
                    $display("FAIL %s kind=%0d actual=%h expected=%h",
                             it.tag, it.kind, actual(it.kind), it.exp);
                end
            end
        end
    end

    task automatic push_all(input string tag);
        logic [7:0] st;
        st = {mext[5], mrs, mws, mext[4:0]};
        q.push_back('{tag, 0, {24'h0, (msel == 8'h8F) ? mlat : 8'hFF}});
        q.push_back('{tag, 1, mw});
        q.push_back('{tag, 2, mr});
        q.push_back('{tag, 3, {24'h0, st}});
        q.push_back('{tag, 4, {31'h0, |st}});
        q.push_back('{tag, 5, mw});
        q.push_back('{tag, 6, mr});
    endtask

    task automatic do_reset(input string tag);
        @(posedge clk); #1;
        rst = 1'b1;
        repeat (2) @(posedge clk);
        #1 rst = 1'b0;
        mw = '0; mr = '0; mws = 1'b0; mrs = 1'b0;
        msel = 8'h00; mlat = 8'hE8;
        push_all(tag);
    endtask

    // driver: one bus cycle, model update, expectation push
    task automatic op(input logic we, input logic [7:0] code,
                      input logic [NV-1:0] wq, input logic [NV-1:0] rq,
                      input logic [5:0] ext, input string tag);
        logic [NV-1:0] cw, cr;
        cw = '0; cr = '0;
        @(posedge clk); #1;
        func_we = we; func_wdata = code; wt_req = wq; rmp_req = rq; ext_bits = ext;
        @(posedge clk); #1;
        func_we = 1'b0; wt_req = '0; rmp_req = '0;
        mext = ext;
        if (we) begin
            msel = code;
            if (code == 8'h8F) begin
                mlat = 8'hE8;
                if (mw != '0) begin
                    for (int i = 0; i < NV - 1; i++)
                        if (cw == '0 && mw[i]) begin cw[i] = 1'b1; mlat = 8'h60 | 8'(i); end
                    if (((mw & ~cw) == '0) && wq == '0) mws = 1'b0;
                end else if (mr != '0) begin
                    for (int i = 0; i < NV - 1; i++)
                        if (cr == '0 && mr[i]) begin cr[i] = 1'b1; mlat = 8'h80 | 8'(i); end
                    if (((mr & ~cr) == '0) && rq == '0) mrs = 1'b0;
                end
            end
        end
        mw = (mw & ~cw) | wq;
        mr = (mr & ~cr) | rq;
        if (wq != '0) mws = 1'b1;
        if (rq != '0) mrs = 1'b1;
        push_all(tag);
    endtask

    initial begin
        mext = '0;
        do_reset("R11 reset state");
        op(0, 8'h00, 32'h0000_0208, 32'h0000_0002, 6'h0, "R8 requests set summary");
        op(1, 8'h45, '0, '0, 6'h0, "R1 other code no service");
        op(1, 8'h8F, '0, '0, 6'h0, "R4 wavetable voice 3");
        op(0, 8'h00, '0, '0, 6'h0, "R7 idle read quiet");
        op(0, 8'h00, '0, '0, 6'h0, "R7 second read quiet");
        op(1, 8'h8F, '0, '0, 6'h0, "R4 R8 wavetable voice 9 drains");
        op(1, 8'h8F, '0, '0, 6'h0, "R5 R9 ramp voice 1 drains");
        op(1, 8'h8F, '0, '0, 6'h0, "R6 nothing pending");
        op(0, 8'h00, '0, '0, 6'h24, "R9 external bits");
        op(0, 8'h00, '0, '0, 6'h00, "R9 line low at zero");

        do_reset("R11 reset again");
        op(0, 8'h00, 32'h8000_0000, 32'h0000_0001, 6'h0, "R3 voice 31 setup");
        op(1, 8'h8F, '0, '0, 6'h0, "R3 voice 31 blocks ramp");

        do_reset("R11 reset third");
        op(0, 8'h00, '0, 32'h0000_0020, 6'h0, "R10 setup");
        op(1, 8'h8F, '0, 32'h0000_0020, 6'h0, "R10 request beats clear");
        op(1, 8'h8F, 32'h0000_0010, 32'h0000_0001, 6'h0, "R10 new class during ramp service");
        op(1, 8'h8F, '0, '0, 6'h0, "R4 wavetable after late arrival");

        do_reset("R11 reset fourth");
        op(0, 8'h00, 32'hFFFF_FFFF, '0, 6'h0, "R2 fill all voices");
        for (int k = 0; k < NV - 1; k++)
            op(1, 8'h8F, '0, '0, 6'h0, "R2 ascending scan");
        op(1, 8'h8F, '0, '0, 6'h0, "R2 voice 31 left over");

        @(negedge clk);
        @(negedge clk);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule